// File: doc/BRIEF.md
# Multi-Channel DMA Control/Status Register Bank

This block is the host-facing register file of a DMA controller that serves four, eight or twelve channels. The host reaches it through a plain 32-bit word-addressed read/write port. The block stores the transfer mode, the transfer direction and the interrupt enable of every channel, and it drives the mode and direction to the channel engines. It also collects per-channel completion pulses, error pulses and live engine state codes into status words. The host clears the sticky flags in those words by writing ones. All enabled, pending flags are merged into one interrupt request.

The lower eight channels and the upper four channels are kept in separate control and status words. The upper channels' enable bits sit eight positions above their channel number. Each channel also has a window of four descriptor registers. This block decodes those windows, but the registers themselves live in the engines. A write to a window produces a one-hot strobe towards the owning engine. A read returns that engine's data.

Reads go through a two-state access machine. State ST_IDLE moves to ST_RESP on a read command. ST_RESP stays in ST_RESP on a back-to-back read and returns to ST_IDLE otherwise. The response is valid only while the machine is in ST_RESP.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, all modes are 0 (disabled), all directions are 0, all enables and flags are clear, `irq` is low, and words 0x00, 0x08 and 0x10 read as 0 while the state inputs are 0.
- R2: Word 0x00 holds channels 0..7 and word 0x0C holds channels 8..11 (lane = channel mod 8). In each lane, bits [4L+1:4L] are the mode (0 off, 1 chained, 2 one-shot) and bit 4L+2 is the direction (1 memory to device). Bit 4L+3 and lanes with no channel read 0. `ch_mode[2c+1:2c]` and `ch_dir[c]` follow the stored fields, and they change only on a write to the owning word.
- R3: A mode value of 3 written to a lane is stored as 0 (disabled), and the direction bit of that lane is still taken.
- R4: Word 0x08 holds the enables: bit c for channels 0..7 and bit c+8 for channels 8..11. All other bits read 0.
- R5: Word 0x10 (channels 0..7) and word 0x18 (channels 8..11) hold the per-lane flags. Bit L is the interrupt flag, bit L+8 is the error flag, and bits [17+2L:16+2L] are the live value of `ch_state` for the channel.
- R6: A one-cycle pulse on `ch_done[c]` sets the channel's interrupt flag. A pulse on `ch_err[c]` sets both the interrupt flag and the error flag. The flags then stay set.
- R7: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends set.
- R8: `irq` is high exactly when some channel has both its interrupt flag and its enable set.
- R9: Address 0x20 + 16*c + 4*k selects descriptor register k of channel c. A write there pulses `desc_wr[c]` alone, with `desc_reg` = k and `desc_wdata` equal to the host data. A read there returns `desc_rdata[32c+31:32c]`.
- R10: Words 0x04, 0x14 and 0x1C, and addresses above the last channel window, read 0. Writes to them change nothing and raise no descriptor strobe.
- R11: `host_rvalid` and `host_rdata` are presented in the cycle after `host_rd` is sampled. `host_rvalid` is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write command |
| host_rd | input | 1 | Host read command |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response valid |
| desc_wr | output | NUM_CH | One-hot descriptor write strobe |
| desc_rd | output | NUM_CH | One-hot descriptor read strobe |
| desc_reg | output | 2 | Descriptor register index in the window |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32*NUM_CH | Descriptor read data from each engine |
| ch_done | input | NUM_CH | Completion pulses |
| ch_err | input | NUM_CH | Error pulses |
| ch_state | input | 2*NUM_CH | Live engine state codes (0 idle, 1 fetch, 2 wait, 3 move) |
| ch_mode | output | 2*NUM_CH | Per-channel mode |
| ch_dir | output | NUM_CH | Per-channel direction |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `ch_done` and `ch_err` are synchronous single-cycle events. They also assume that the host issues at most one command per cycle, so `host_wr` and `host_rd` are never high together. The bench drives both commands from tasks that raise one strobe for exactly one cycle at the falling edge, and it never combines them. The bench holds `ch_state` at fixed codes while the status words are read, so the live field returns a known value.

// File: rtl/dmac_regbank_pkg.sv
package dmac_regbank_pkg;

    localparam int LANES_PER_WORD = 8;
    localparam int FIELD_BITS     = 4;
    localparam int HI_IE_SHIFT    = 8;
    localparam int ERR_SHIFT      = 8;
    localparam int STATE_BASE     = 16;

    localparam logic [1:0] MODE_OFF    = 2'd0;
    localparam logic [1:0] MODE_CHAIN  = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;
    localparam logic [1:0] MODE_RSVD   = 2'd3;

    localparam int W_CTRL_LO   = 0;
    localparam int W_IE        = 2;
    localparam int W_CTRL_HI   = 3;
    localparam int W_STAT_LO   = 4;
    localparam int W_STAT_HI   = 6;
    localparam int W_DESC_BASE = 8;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } acc_state_e;

    typedef struct packed {
        logic ctrl_lo;
        logic ie;
        logic ctrl_hi;
        logic stat_lo;
        logic stat_hi;
    } word_sel_t;

endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
    import dmac_regbank_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int WORD_W = 6
) (
    input  logic [WORD_W-1:0] word,
    output word_sel_t         sel,
    output logic [NUM_CH-1:0] desc_hit,
    output logic [1:0]        desc_reg
);
    logic [WORD_W-1:0] dofs;
    logic              in_desc;

    assign dofs     = word - WORD_W'(W_DESC_BASE);
    assign in_desc  = (word >= WORD_W'(W_DESC_BASE));
    assign desc_reg = word[1:0];

    always_comb begin
        sel         = '0;
        sel.ctrl_lo = (word == WORD_W'(W_CTRL_LO));
        sel.ie      = (word == WORD_W'(W_IE));
        sel.ctrl_hi = (word == WORD_W'(W_CTRL_HI));
        sel.stat_lo = (word == WORD_W'(W_STAT_LO));
        sel.stat_hi = (word == WORD_W'(W_STAT_HI));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign desc_hit[c] = in_desc && (dofs[WORD_W-1:2] == (WORD_W-2)'(c));
    end
endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
    import dmac_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_field,
    input  logic [2:0] field,
    input  logic       wr_ie,
    input  logic       ie_bit,
    output logic [1:0] mode,
    output logic       dir,
    output logic       ie
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_OFF;
            dir  <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (wr_field) begin
                mode <= (field[1:0] == MODE_RSVD) ? MODE_OFF : field[1:0];
                dir  <= field[2];
            end
            if (wr_ie) begin
                ie <= ie_bit;
            end
        end
    end
endmodule

// File: rtl/dmac_chan_status.sv
module dmac_chan_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_irq,
    input  logic clr_err,
    input  logic done,
    input  logic err,
    output logic irq_flag,
    output logic err_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            irq_flag <= done | err | (irq_flag & ~clr_irq);
            err_flag <= err | (err_flag & ~clr_err);
        end
    end
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
    import dmac_regbank_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    output logic                 host_rvalid,
    output logic [NUM_CH-1:0]    desc_wr,
    output logic [NUM_CH-1:0]    desc_rd,
    output logic [1:0]           desc_reg,
    output logic [31:0]          desc_wdata,
    input  logic [32*NUM_CH-1:0] desc_rdata,
    input  logic [NUM_CH-1:0]    ch_done,
    input  logic [NUM_CH-1:0]    ch_err,
    input  logic [2*NUM_CH-1:0]  ch_state,
    output logic [2*NUM_CH-1:0]  ch_mode,
    output logic [NUM_CH-1:0]    ch_dir,
    output logic                 irq
);
    localparam int WORD_W = ADDR_W - 2;

    word_sel_t         sel;
    logic [NUM_CH-1:0] desc_hit;
    logic [NUM_CH-1:0] ie_q;
    logic [NUM_CH-1:0] irq_flag;
    logic [NUM_CH-1:0] err_flag;
    logic              unused_addr_lsb;
    acc_state_e        state_q, state_d;
    logic [31:0]       rdata_q, rd_mux;

    assign unused_addr_lsb = ^host_addr[1:0];

    dmac_addr_dec #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_dec (
        .word     (host_addr[ADDR_W-1:2]),
        .sel      (sel),
        .desc_hit (desc_hit),
        .desc_reg (desc_reg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int  LANE    = c % LANES_PER_WORD;
        localparam int  FBIT    = FIELD_BITS * LANE;
        localparam int  IE_BIT  = (c < LANES_PER_WORD) ? c : c + HI_IE_SHIFT;
        localparam bit  UPPER   = (c >= LANES_PER_WORD);
        logic own_ctrl, own_stat;
        assign own_ctrl = UPPER ? sel.ctrl_hi : sel.ctrl_lo;
        assign own_stat = UPPER ? sel.stat_hi : sel.stat_lo;

        dmac_chan_ctrl u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_field (host_wr & own_ctrl),
            .field    (host_wdata[FBIT+:3]),
            .wr_ie    (host_wr & sel.ie),
            .ie_bit   (host_wdata[IE_BIT]),
            .mode     (ch_mode[2*c+:2]),
            .dir      (ch_dir[c]),
            .ie       (ie_q[c])
        );

        dmac_chan_status u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_irq  (host_wr & own_stat & host_wdata[LANE]),
            .clr_err  (host_wr & own_stat & host_wdata[LANE+ERR_SHIFT]),
            .done     (ch_done[c]),
            .err      (ch_err[c]),
            .irq_flag (irq_flag[c]),
            .err_flag (err_flag[c])
        );
    end

    assign desc_wr    = host_wr ? desc_hit : '0;
    assign desc_rd    = host_rd ? desc_hit : '0;
    assign desc_wdata = host_wdata;
    assign irq        = |(irq_flag & ie_q);

    // Read data selection
    always_comb begin
        logic [31:0] ctrl_lo_w, ctrl_hi_w, ie_w, stat_lo_w, stat_hi_w, desc_w;
        ctrl_lo_w = '0; ctrl_hi_w = '0; ie_w = '0;
        stat_lo_w = '0; stat_hi_w = '0; desc_w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c < LANES_PER_WORD) begin
                ctrl_lo_w[FIELD_BITS*c +: 3]       = {ch_dir[c], ch_mode[2*c+:2]};
                ie_w[c]                            = ie_q[c];
                stat_lo_w[c]                       = irq_flag[c];
                stat_lo_w[c+ERR_SHIFT]             = err_flag[c];
                stat_lo_w[STATE_BASE+2*c +: 2]     = ch_state[2*c+:2];
            end else begin
                ctrl_hi_w[FIELD_BITS*(c-8) +: 3]   = {ch_dir[c], ch_mode[2*c+:2]};
                ie_w[c+HI_IE_SHIFT]                = ie_q[c];
                stat_hi_w[c-8]                     = irq_flag[c];
                stat_hi_w[c-8+ERR_SHIFT]           = err_flag[c];
                stat_hi_w[STATE_BASE+2*(c-8) +: 2] = ch_state[2*c+:2];
            end
            if (desc_hit[c]) begin
                desc_w = desc_rdata[32*c+:32];
            end
        end
        rd_mux = ({32{sel.ctrl_lo}} & ctrl_lo_w) | ({32{sel.ctrl_hi}} & ctrl_hi_w)
               | ({32{sel.ie}} & ie_w) | ({32{sel.stat_lo}} & stat_lo_w)
               | ({32{sel.stat_hi}} & stat_hi_w) | desc_w;
    end

    // Access machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (host_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // Access machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = host_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = host_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Access machine: outputs
    always_comb begin
        host_rvalid = (state_q == ST_RESP);
        host_rdata  = rdata_q;
    end
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk #(
    parameter int NUM_CH = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_wr,
    input logic                host_rd,
    input logic                host_rvalid,
    input logic [NUM_CH-1:0]   desc_wr,
    input logic [NUM_CH-1:0]   ch_done,
    input logic [NUM_CH-1:0]   ch_err,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_dir,
    input logic [NUM_CH-1:0]   irq_flag,
    input logic [NUM_CH-1:0]   err_flag,
    input logic                irq
);
    p_rvalid_follows_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    p_rvalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    p_desc_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(desc_wr));
    p_desc_only_on_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |-> (desc_wr == '0));
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> ($stable(ch_mode) && $stable(ch_dir)));
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(ch_done | ch_err) || host_wr));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[2*c+:2] != 2'd3);
        p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_done[c] |=> irq_flag[c]);
        p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_err[c] |=> (err_flag[c] && irq_flag[c]));
        p_flag_clear_needs_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_flag[c]) |-> $past(host_wr));
    end
endmodule

bind dmac_regbank dmac_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .desc_wr     (desc_wr),
    .ch_done     (ch_done),
    .ch_err      (ch_err),
    .ch_mode     (ch_mode),
    .ch_dir      (ch_dir),
    .irq_flag    (irq_flag),
    .err_flag    (err_flag),
    .irq         (irq)
);

// File: tb/sim_dmac_regbank.sv
`timescale 1ns/1ps
module sim_dmac_regbank;
    localparam int NCH = 12;
    localparam int AW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0]     host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              host_rvalid;
    logic [NCH-1:0]    desc_wr, desc_rd;
    logic [1:0]        desc_reg;
    logic [31:0]       desc_wdata;
    logic [32*NCH-1:0] desc_rdata;
    logic [NCH-1:0]    ch_done = '0, ch_err = '0;
    logic [2*NCH-1:0]  ch_state = '0;
    logic [2*NCH-1:0]  ch_mode;
    logic [NCH-1:0]    ch_dir;
    logic              irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++)
            desc_rdata[32*c+:32] = {16'hDE5C, 8'(c), 6'b0, desc_reg};
    end

    dmac_regbank #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 mode", {8'b0, ch_mode}, 32'd0);
        check("R1 dir", {20'b0, ch_dir}, 32'd0);
        check("R11 idle rvalid", {31'b0, host_rvalid}, 32'd0);
        rd(8'h00, 32'h0, "R1 ctrl_lo");
        rd(8'h08, 32'h0, "R1 ie");
        rd(8'h10, 32'h0, "R1 stat_lo");
        @(negedge clk);

        // R2 low channel fields; lane 1 bit 3 must read 0
        wr(8'h00, 32'h6000_2085);
        check("R2 ch0 mode", {30'b0, ch_mode[1:0]}, 32'd1);
        check("R2 ch3 mode", {30'b0, ch_mode[7:6]}, 32'd2);
        check("R2 ch7 mode", {30'b0, ch_mode[15:14]}, 32'd2);
        check("R2 dir lo", {24'b0, ch_dir[7:0]}, 32'h81);
        rd(8'h00, 32'h6000_2005, "R2 ctrl_lo readback");
        // R2 high channel fields
        wr(8'h0C, 32'hABCD_1006);
        check("R2 ch8 mode", {30'b0, ch_mode[17:16]}, 32'd2);
        check("R2 ch11 mode", {30'b0, ch_mode[23:22]}, 32'd1);
        check("R2 dir hi", {28'b0, ch_dir[11:8]}, 32'h1);
        rd(8'h0C, 32'h0000_1006, "R2 ctrl_hi readback");

        // R3 reserved mode stored as disabled
        wr(8'h00, 32'h6000_2007);
        check("R3 ch0 mode", {30'b0, ch_mode[1:0]}, 32'd0);
        check("R3 ch0 dir", {31'b0, ch_dir[0]}, 32'd1);
        rd(8'h00, 32'h6000_2004, "R3 readback");

        // R10 reserved words
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R10 word 0x04");
        rd(8'h14, 32'h0, "R10 word 0x14");
        rd(8'h1C, 32'h0, "R10 word 0x1C");
        rd(8'h00, 32'h6000_2004, "R10 ctrl untouched");
        check("R10 irq", {31'b0, irq}, 32'd0);

        // R4 enables
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h000F_00FF, "R4 ie layout");

        // R5/R6 status capture
        ch_state[5:4] = 2'd3; ch_state[19:18] = 2'd1;
        ch_done[2] = 1'b1; ch_err[9] = 1'b1;
        @(negedge clk);
        ch_done = '0; ch_err = '0;
        check("R8 irq on", {31'b0, irq}, 32'd1);
        rd(8'h10, 32'h0030_0004, "R5 R6 stat_lo");
        rd(8'h18, 32'h0004_0202, "R5 R6 stat_hi");

        // R8 gating by enables
        wr(8'h08, 32'h0);
        check("R8 all masked", {31'b0, irq}, 32'd0);
        wr(8'h08, 32'h0002_0000);
        check("R8 ch9 enabled", {31'b0, irq}, 32'd1);
        // R7 clears
        wr(8'h18, 32'h0000_0002);
        check("R7 R8 ch9 cleared", {31'b0, irq}, 32'd0);
        rd(8'h18, 32'h0004_0200, "R7 err kept");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0030_0004, "R7 zero write");
        wr(8'h08, 32'h0000_0004);
        check("R8 ch2 enabled", {31'b0, irq}, 32'd1);
        wr(8'h18, 32'h0000_0200);
        rd(8'h18, 32'h0004_0000, "R7 err clear");

        // R7 set wins over clear
        host_wr = 1'b1; host_addr = 8'h10; host_wdata = 32'h4; ch_done[2] = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; ch_done = '0;
        rd(8'h10, 32'h0030_0004, "R7 set wins");
        check("R7 irq kept", {31'b0, irq}, 32'd1);
        wr(8'h10, 32'h4);
        rd(8'h10, 32'h0030_0000, "R7 clear");
        check("R7 irq dropped", {31'b0, irq}, 32'd0);
        // R6 error pulse alone sets both flags
        ch_err[2] = 1'b1;
        @(negedge clk);
        ch_err = '0;
        rd(8'h10, 32'h0030_0404, "R6 err sets both");

        // R9 descriptor windows
        host_wr = 1'b1; host_addr = 8'h78; host_wdata = 32'h1234_5678;
        #1;
        check("R9 strobe", {20'b0, desc_wr}, 32'h20);
        check("R9 reg idx", {30'b0, desc_reg}, 32'd2);
        check("R9 wdata", desc_wdata, 32'h1234_5678);
        @(negedge clk);
        host_wr = 1'b0;
        rd(8'hD4, 32'hDE5C_0B01, "R9 ch11 reg1");
        rd(8'h20, 32'hDE5C_0000, "R9 ch0 reg0");
        // R10 beyond last window
        host_wr = 1'b1; host_addr = 8'hE0; host_wdata = 32'hFFFF_FFFF;
        #1;
        check("R10 no strobe", {20'b0, desc_wr}, 32'h0);
        @(negedge clk);
        host_wr = 1'b0;
        rd(8'hE0, 32'h0, "R10 beyond windows");
        rd(8'h00, 32'h6000_2004, "R10 ctrl after stray write");
        @(negedge clk);
        @(negedge clk);
        check("R11 queue drained", exp_q.size(), 32'd0);
        check("R11 rvalid low", {31'b0, host_rvalid}, 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule